// File: doc/BRIEF.md
# Carry-Aware Integer Add/Subtract Unit

This block runs the full family of fixed-point add and subtract-from operations on a single adder. Each operation is rewritten as `first + second + carry_in`. The first operand is either `ra` or its bitwise complement. The second operand is `rb`, all zeros or all ones. The carry-in is 0, 1 or the incoming carry flag. A 9-bit extended opcode selects all three choices.

Alongside the sum, the unit works out the new carry (CA), overflow (OV) and sticky summary-overflow (SO) flags. The surrounding pipeline writes these back into its exception register. The overflow-enable input `oe` affects only the OV/SO bookkeeping. It never changes the sum or the carry.

A request is presented with `in_valid`. The result and all three flags appear registered on the next clock edge together with `out_valid`. When no request is presented, the outputs keep their last values. A parameter selects between two adder implementations: a flat wide add or a generated per-bit ripple chain.

Top module: `adsu_unit`

## Requirements
- R1: Opcode 266 yields ra+rb, opcode 40 yields ~ra+rb+1, and opcode 104 yields ~ra+1. These three leave CA equal to `ca_in`.
- R2: Opcode 10 computes ra+rb and opcode 8 computes ~ra+rb+1. Both write the carry-out into CA.
- R3: Opcode 138 computes ra+rb+ca_in and opcode 136 computes ~ra+rb+ca_in. Both write the carry-out into CA.
- R4: Opcode 234 computes ra+0xFFFFFFFF+ca_in and opcode 232 computes ~ra+0xFFFFFFFF+ca_in. Both write the carry-out into CA.
- R5: Opcode 202 computes ra+ca_in and opcode 200 computes ~ra+ca_in. Both write the carry-out into CA.
- R6: Where CA is written, it equals the carry out of bit 31 of the complete three-input sum, including the carry-in.
- R7: With `oe`=1 and a recognised opcode, OV becomes the signed (two's complement) overflow of the 32-bit sum. SO becomes `so_in` OR that overflow, so SO is never cleared.
- R8: With `oe`=0, `ov_out` equals `ov_in` and `so_out` equals `so_in`.
- R9: Any other opcode value gives a zero result and passes CA, OV and SO through unchanged, whatever `oe` is.
- R10: Outputs are registered. `out_valid` rises one cycle after `in_valid`. While `in_valid` is low, result and flags hold their previous values. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| xo | input | 9 | Extended opcode |
| oe | input | 1 | Overflow-recording variant select |
| ra | input | 32 | First source operand |
| rb | input | 32 | Second source operand |
| ca_in | input | 1 | Current carry flag |
| ov_in | input | 1 | Current overflow flag |
| so_in | input | 1 | Current summary-overflow flag |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Sum |
| ca_out | output | 1 | New carry flag |
| ov_out | output | 1 | New overflow flag |
| so_out | output | 1 | New summary-overflow flag |

## Verification
Directed operands aim at the edges of the adder:
- Values straddling 0x7FFFFFFF and 0x80000000 separate signed overflow from unsigned carry.
- Zero and all-ones operands with either carry-in show whether the complement and the carry-in are chosen correctly for each opcode pair.
- Setting `ov_in` and `so_in` high with `oe` low, and then with `oe` high but no overflow, distinguishes hold, sticky and clear behaviour.

After the directed set, a long stream of random operands, flags and opcodes, with some unrecognised codes mixed in, is compared every cycle against a behavioural model. Idle cycles with changing inputs confirm that the outputs hold.

// File: rtl/adsu_pkg.sv
package adsu_pkg;

   typedef enum logic [1:0] {
      B_REG  = 2'd0,
      B_ZERO = 2'd1,
      B_ONES = 2'd2
   } bsel_e;

   typedef enum logic [1:0] {
      CI_ZERO  = 2'd0,
      CI_ONE   = 2'd1,
      CI_CARRY = 2'd2
   } csel_e;

   typedef struct packed {
      logic  known;
      logic  inv_a;
      bsel_e bsel;
      csel_e csel;
      logic  wr_ca;
   } ctl_t;

   localparam int XO_ADD    = 266;
   localparam int XO_SUBF   = 40;
   localparam int XO_ADDC   = 10;
   localparam int XO_SUBFC  = 8;
   localparam int XO_NEG    = 104;
   localparam int XO_ADDE   = 138;
   localparam int XO_SUBFE  = 136;
   localparam int XO_ADDME  = 234;
   localparam int XO_SUBFME = 232;
   localparam int XO_ADDZE  = 202;
   localparam int XO_SUBFZE = 200;

endpackage

// File: rtl/adsu_decode.sv
module adsu_decode
   import adsu_pkg::*;
#(
   parameter int XO_W = 9
) (
   input  logic [XO_W-1:0] xo,
   output ctl_t            ctl
);

   generate
      if (XO_W < 9) begin : g_bad_xo
         $error("adsu_decode: XO_W must be at least 9");
      end
   endgenerate

   function automatic ctl_t mk(input logic inv, input bsel_e b, input csel_e c,
                               input logic w);
      ctl_t t;
      t.known = 1'b1;
      t.inv_a = inv;
      t.bsel  = b;
      t.csel  = c;
      t.wr_ca = w;
      return t;
   endfunction

   always_comb begin
      ctl = '{known: 1'b0, inv_a: 1'b0, bsel: B_ZERO, csel: CI_ZERO, wr_ca: 1'b0};
      case (xo)
         XO_W'(XO_ADD):    ctl = mk(1'b0, B_REG,  CI_ZERO,  1'b0);
         XO_W'(XO_SUBF):   ctl = mk(1'b1, B_REG,  CI_ONE,   1'b0);
         XO_W'(XO_NEG):    ctl = mk(1'b1, B_ZERO, CI_ONE,   1'b0);
         XO_W'(XO_ADDC):   ctl = mk(1'b0, B_REG,  CI_ZERO,  1'b1);
         XO_W'(XO_SUBFC):  ctl = mk(1'b1, B_REG,  CI_ONE,   1'b1);
         XO_W'(XO_ADDE):   ctl = mk(1'b0, B_REG,  CI_CARRY, 1'b1);
         XO_W'(XO_SUBFE):  ctl = mk(1'b1, B_REG,  CI_CARRY, 1'b1);
         XO_W'(XO_ADDME):  ctl = mk(1'b0, B_ONES, CI_CARRY, 1'b1);
         XO_W'(XO_SUBFME): ctl = mk(1'b1, B_ONES, CI_CARRY, 1'b1);
         XO_W'(XO_ADDZE):  ctl = mk(1'b0, B_ZERO, CI_CARRY, 1'b1);
         XO_W'(XO_SUBFZE): ctl = mk(1'b1, B_ZERO, CI_CARRY, 1'b1);
         default: ;
      endcase
   end

endmodule

// File: rtl/adsu_operands.sv
module adsu_operands
   import adsu_pkg::*;
#(
   parameter int W = 32
) (
   input  ctl_t         ctl,
   input  logic [W-1:0] ra,
   input  logic [W-1:0] rb,
   input  logic         ca_in,
   output logic [W-1:0] src1,
   output logic [W-1:0] src2,
   output logic         cin
);

   always_comb begin
      src1 = ctl.inv_a ? ~ra : ra;
      case (ctl.bsel)
         B_REG:   src2 = rb;
         B_ONES:  src2 = '1;
         default: src2 = '0;
      endcase
      case (ctl.csel)
         CI_ONE:   cin = 1'b1;
         CI_CARRY: cin = ca_in;
         default:  cin = 1'b0;
      endcase
   end

endmodule

// File: rtl/adsu_adder.sv
module adsu_adder #(
   parameter int W     = 32,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);

   generate
      if (W < 2) begin : g_bad_w
         $error("adsu_adder: W must be at least 2");
      end
      if (STYLE != 0 && STYLE != 1) begin : g_bad_style
         $error("adsu_adder: STYLE must be 0 or 1");
      end

      if (STYLE == 0) begin : g_flat
         logic [W:0] wide;
         assign wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
         assign sum  = wide[W-1:0];
         assign cout = wide[W];
         assign ovf  = (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1]);
      end else begin : g_ripple
         logic [W:0] c;
         assign c[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]   = a[i] ^ b[i] ^ c[i];
            assign c[i+1]   = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
         end
         assign cout = c[W];
         assign ovf  = c[W] ^ c[W-1];
      end
   endgenerate

endmodule

// File: rtl/adsu_flags.sv
module adsu_flags
   import adsu_pkg::*;
(
   input  ctl_t ctl,
   input  logic oe,
   input  logic cout,
   input  logic ovf,
   input  logic ca_in,
   input  logic ov_in,
   input  logic so_in,
   output logic ca_nxt,
   output logic ov_nxt,
   output logic so_nxt
);

   logic rec_ov;

   always_comb begin
      rec_ov = ctl.known & oe;
      ca_nxt = (ctl.known & ctl.wr_ca) ? cout : ca_in;
      ov_nxt = rec_ov ? ovf : ov_in;
      so_nxt = rec_ov ? (so_in | ovf) : so_in;
   end

endmodule

// File: rtl/adsu_unit.sv
module adsu_unit
   import adsu_pkg::*;
#(
   parameter int W           = 32,
   parameter int XO_W        = 9,
   parameter int ADDER_STYLE = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [XO_W-1:0] xo,
   input  logic            oe,
   input  logic [W-1:0]    ra,
   input  logic [W-1:0]    rb,
   input  logic            ca_in,
   input  logic            ov_in,
   input  logic            so_in,
   output logic            out_valid,
   output logic [W-1:0]    result,
   output logic            ca_out,
   output logic            ov_out,
   output logic            so_out
);

   ctl_t         ctl;
   logic [W-1:0] src1, src2, sum;
   logic         cin, cout, ovf;
   logic         ca_nxt, ov_nxt, so_nxt;

   adsu_decode #(.XO_W(XO_W)) u_dec (.xo(xo), .ctl(ctl));

   adsu_operands #(.W(W)) u_opnd (
      .ctl(ctl), .ra(ra), .rb(rb), .ca_in(ca_in),
      .src1(src1), .src2(src2), .cin(cin)
   );

   adsu_adder #(.W(W), .STYLE(ADDER_STYLE)) u_add (
      .a(src1), .b(src2), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
   );

   adsu_flags u_flg (
      .ctl(ctl), .oe(oe), .cout(cout), .ovf(ovf),
      .ca_in(ca_in), .ov_in(ov_in), .so_in(so_in),
      .ca_nxt(ca_nxt), .ov_nxt(ov_nxt), .so_nxt(so_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         ca_out    <= 1'b0;
         ov_out    <= 1'b0;
         so_out    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= ctl.known ? sum : '0;
            ca_out <= ca_nxt;
            ov_out <= ov_nxt;
            so_out <= so_nxt;
         end
      end
   end

   assert_so_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && oe && so_in) |=> so_out);

   assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !oe) |=> (ov_out == $past(ov_in) && so_out == $past(so_in)));

   assert_unknown_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !ctl.known) |=> (result == '0 && ca_out == $past(ca_in)));

   assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(so_out)));

endmodule

// File: tb/sim_adsu_unit.sv
module sim_adsu_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [8:0]  xo = '0;
   logic        oe = 1'b0;
   logic [31:0] ra = '0, rb = '0;
   logic        ca_in = 1'b0, ov_in = 1'b0, so_in = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        ca_out, ov_out, so_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic        e_valid = 1'b0;
   logic [31:0] e_res = '0;
   logic        e_ca = 1'b0, e_ov = 1'b0, e_so = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adsu_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .xo(xo), .oe(oe),
      .ra(ra), .rb(rb), .ca_in(ca_in), .ov_in(ov_in), .so_in(so_in),
      .out_valid(out_valid), .result(result), .ca_out(ca_out),
      .ov_out(ov_out), .so_out(so_out)
   );

   function automatic string tag_of(input logic [8:0] x);
      case (x)
         9'd266, 9'd40, 9'd104: return "R1";
         9'd10, 9'd8:           return "R2";
         9'd138, 9'd136:        return "R3";
         9'd234, 9'd232:        return "R4";
         9'd202, 9'd200:        return "R5";
         default:               return "R9";
      endcase
   endfunction

   task automatic model(input logic [8:0] x, input logic o, input logic [31:0] a,
                        input logic [31:0] b, input logic ci, input logic vi,
                        input logic si);
      bit known = 1'b1, inv = 1'b0, wca = 1'b1;
      logic [31:0] s2;
      logic c;
      logic [32:0] tot;
      longint sg;
      case (x)
         9'd266: begin inv = 0; s2 = b;  c = 0;  wca = 0; end
         9'd40:  begin inv = 1; s2 = b;  c = 1;  wca = 0; end
         9'd104: begin inv = 1; s2 = 0;  c = 1;  wca = 0; end
         9'd10:  begin inv = 0; s2 = b;  c = 0;  end
         9'd8:   begin inv = 1; s2 = b;  c = 1;  end
         9'd138: begin inv = 0; s2 = b;  c = ci; end
         9'd136: begin inv = 1; s2 = b;  c = ci; end
         9'd234: begin inv = 0; s2 = '1; c = ci; end
         9'd232: begin inv = 1; s2 = '1; c = ci; end
         9'd202: begin inv = 0; s2 = 0;  c = ci; end
         9'd200: begin inv = 1; s2 = 0;  c = ci; end
         default: begin known = 0; s2 = 0; c = 0; end
      endcase
      if (!known) begin
         e_res = '0; e_ca = ci; e_ov = vi; e_so = si;
      end else begin
         tot = {1'b0, (inv ? ~a : a)} + {1'b0, s2} + 33'(c);
         sg  = longint'($signed(inv ? ~a : a)) + longint'($signed(s2)) + longint'(c);
         e_res = tot[31:0];
         e_ca  = wca ? tot[32] : ci;
         if (o) begin
            e_ov = (sg > 64'sd2147483647) || (sg < -64'sd2147483648);
            e_so = si | e_ov;
         end else begin
            e_ov = vi; e_so = si;
         end
      end
   endtask

   task automatic compare(input string tag);
      bit bad = 1'b0;
      checks++;
      if (out_valid !== e_valid) begin bad = 1; $display("FAIL %s out_valid got %b exp %b", tag, out_valid, e_valid); end
      if (result !== e_res) begin bad = 1; $display("FAIL %s result got %h exp %h", tag, result, e_res); end
      if (ca_out !== e_ca) begin bad = 1; $display("FAIL %s ca got %b exp %b", tag, ca_out, e_ca); end
      if (ov_out !== e_ov) begin bad = 1; $display("FAIL %s ov got %b exp %b", tag, ov_out, e_ov); end
      if (so_out !== e_so) begin bad = 1; $display("FAIL %s so got %b exp %b", tag, so_out, e_so); end
      if (bad) fails++;
   endtask

   task automatic apply(input logic v, input logic [8:0] x, input logic o,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic ci, input logic vi, input logic si,
                        input string tag);
      in_valid = v; xo = x; oe = o; ra = a; rb = b;
      ca_in = ci; ov_in = vi; so_in = si;
      e_valid = v;
      if (v) model(x, o, a, b, ci, vi, si);
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare("R10 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R10 reset");

      // R1 basic forms
      apply(1, 9'd266, 0, 32'd1, 32'd2, 1, 0, 0, "R1 add");
      apply(1, 9'd40,  0, 32'd5, 32'd3, 0, 0, 0, "R1 subf");
      apply(1, 9'd104, 0, 32'd0, 32'd9, 0, 0, 0, "R1 neg zero keeps CA");
      apply(1, 9'd104, 1, 32'h8000_0000, 0, 1, 0, 0, "R7 neg overflow");
      // R2 carry record
      apply(1, 9'd10, 0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R2 addc carry");
      apply(1, 9'd8,  0, 32'd0, 32'd0, 0, 0, 0, "R2 subfc zero");
      // R3
      apply(1, 9'd138, 0, 32'hFFFF_FFFE, 32'd1, 1, 0, 0, "R3 adde");
      apply(1, 9'd136, 0, 32'd7, 32'd7, 0, 0, 0, "R3 subfe");
      // R4
      apply(1, 9'd234, 0, 32'd0, 32'd0, 0, 0, 0, "R4 addme ca0");
      apply(1, 9'd234, 0, 32'd0, 32'd0, 1, 0, 0, "R4 addme ca1");
      apply(1, 9'd232, 0, 32'hFFFF_FFFF, 32'd0, 1, 0, 0, "R4 subfme");
      // R5
      apply(1, 9'd202, 0, 32'hFFFF_FFFF, 32'd0, 1, 0, 0, "R5 addze wrap");
      apply(1, 9'd200, 0, 32'hFFFF_FFFF, 32'd0, 1, 0, 0, "R5 subfze");
      // R6 carry includes carry-in
      apply(1, 9'd138, 0, 32'hFFFF_FFFF, 32'd0, 1, 0, 0, "R6 carry from cin");
      // R7 overflow and sticky
      apply(1, 9'd266, 1, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, "R7 add overflow");
      apply(1, 9'd266, 1, 32'd1, 32'd1, 0, 1, 1, "R7 sticky no ovf");
      apply(1, 9'd40, 1, 32'd1, 32'h8000_0000, 0, 0, 0, "R7 subf overflow");
      // R8 hold with oe=0
      apply(1, 9'd266, 0, 32'h7FFF_FFFF, 32'd1, 0, 1, 1, "R8 hold set");
      apply(1, 9'd266, 0, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, "R8 hold clear");
      // R9 unknown
      apply(1, 9'd0,   1, 32'h1234, 32'h5678, 1, 1, 0, "R9 unknown 0");
      apply(1, 9'd511, 1, 32'h7FFF_FFFF, 32'd1, 0, 0, 1, "R9 unknown 511");
      apply(1, 9'd267, 0, 32'd3, 32'd4, 1, 0, 1, "R9 unknown 267");
      // R10 idle hold
      apply(1, 9'd266, 0, 32'd10, 32'd20, 0, 0, 0, "R1 add");
      apply(0, 9'd40, 1, 32'hDEAD, 32'hBEEF, 1, 1, 1, "R10 idle hold");
      apply(0, 9'd8, 1, 32'h1, 32'h2, 0, 1, 0, "R10 idle hold");

      for (int i = 0; i < 3000; i++) begin
         logic [8:0] x;
         int k = $urandom_range(0, 12);
         case (k)
            0: x = 9'd266;  1: x = 9'd40;  2: x = 9'd10;  3: x = 9'd8;
            4: x = 9'd104;  5: x = 9'd138; 6: x = 9'd234; 7: x = 9'd136;
            8: x = 9'd232;  9: x = 9'd202; 10: x = 9'd200;
            default: x = 9'($urandom);
         endcase
         apply(($urandom_range(0, 7) != 0), x, 1'($urandom), $urandom, $urandom,
               1'($urandom), 1'($urandom), 1'($urandom), tag_of(x));
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule